// File: doc/BRIEF.md
# Internal Control Register File with Masked Writes

This block holds the 64-bit control registers of a processor core. They are reached by index through one read port and one write port. Each index has its own rule. Some registers are plain scratch storage. Some keep only selected bits of the written data, and two are cleared by any write. Some are read-only and others are write-only, and indices with no register behind them are refused. An access the rule forbids raises a fault flag instead of touching state.

One register, the cycle register, merges two sources when read. Its upper half is stored and its lower half is a live free-running 32-bit cycle count. Writes to the invalidate and tag registers emit one-cycle command pulses to the translation buffers, which sit outside this block. The written address, and for an insert the stored page-table entry, go out with the pulse.

Top module: `ctrlreg_file`

## Requirements
- R1: After reset every register reads zero. The exceptions are index 9 (miscellaneous control), which reads 0x6, and scratch index 7, which reads the CPU_ID parameter. All outputs are zero after reset.
- R2: Writes keep only masked bits, and the masked-out bits read back as zero. The masks are: index 10 (level) 0x1f, indices 11 and 12 (trap request/enable) 0xf, indices 13 and 14 (mode) 0x18, indices 18 and 19 (cache mode) 0x3f, index 20 (address space) 0x7f0, and indices 21 and 22 (page-table base) bits 63 to 30.
- R3: A write to index 15 (return address) stores the data with bit 1 forced to zero.
- R4: Any write to index 16 or 17 (error summary and error mask) leaves the register at zero, whatever the data.
- R5: Indices 32 and 33 are read-only. A write to either raises wr_fault and leaves the value unchanged.
- R6: Indices 40 to 44 are write-only. A read of one of them gives rd_fault=1 with rd_data=0.
- R7: An index outside 0-24, 32, 33 and 40-44 is unknown. A read gives rd_fault=1 with data 0. A write gives wr_fault=1 and changes no register and raises no pulse.
- R8: Reading index 23 returns the stored bits 63:32 above the low 32 bits of a cycle counter. The counter is zero in reset and adds one on every clock edge after reset.
- R9: A write to index 40 or 41 raises inv_i_all or inv_d_all respectively for exactly one cycle. At most one command pulse is high at any time.
- R10: A write to index 42 or 43 raises inv_i_one or inv_d_one respectively for one cycle, with op_addr equal to the written data.
- R11: A write to index 44 raises ins_d for one cycle. op_addr carries the written tag and op_pte carries the value of index 24 (page-table entry) at the time of the write.
- R12: rd_data, rd_fault, wr_fault and the pulses are registered and appear one cycle after the request. A write is visible to a read requested in the next cycle. A read of the index written in the same cycle returns the old value.
- R13: Indices 0-8, 9, 23 and 24 store all 64 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | 6 | Read index |
| rd_data | output | 64 | Read data, one cycle after rd_en, held otherwise |
| rd_fault | output | 1 | Read refused, one cycle after rd_en |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | Write refused, one-cycle flag |
| inv_i_all | output | 1 | Instruction-side invalidate-all pulse |
| inv_d_all | output | 1 | Data-side invalidate-all pulse |
| inv_i_one | output | 1 | Instruction-side single-address invalidate pulse |
| inv_d_one | output | 1 | Data-side single-address invalidate pulse |
| ins_d | output | 1 | Data-side insert pulse |
| op_addr | output | 64 | Address or tag for the current command |
| op_pte | output | 64 | Page-table entry for an insert |

## Verification
Every result of this block is due exactly one clock edge after its request. That holds for read data, the read fault, the write fault and every command pulse. A write's effect can first be read by a request placed in the following cycle. The bench drives each request on a falling edge, removes it on the next falling edge, and checks the registered outputs there. It then sweeps all 64 indices after reset, after an all-ones write and after an index-dependent pattern. For the cycle register it counts edges since reset itself and expects the count as it stood before the capturing edge.

// File: rtl/ctrlreg_pkg.sv
// Package: index map, per-index access attributes and reset values of
// the control register file. Assumes a 6-bit index space.
package ctrlreg_pkg;

    localparam int DATA_W    = 64;
    localparam int IDX_W     = 6;
    localparam int NIDX      = 1 << IDX_W;
    localparam int SCRATCH_N = 8;
    localparam int ID_SLOT   = 7;
    localparam int CNT_W     = DATA_W / 2;

    localparam logic [IDX_W-1:0] IX_BASE     = 6'd8;
    localparam logic [IDX_W-1:0] IX_MISC     = 6'd9;
    localparam logic [IDX_W-1:0] IX_LEVEL    = 6'd10;
    localparam logic [IDX_W-1:0] IX_TRAP_REQ = 6'd11;
    localparam logic [IDX_W-1:0] IX_TRAP_EN  = 6'd12;
    localparam logic [IDX_W-1:0] IX_IMODE    = 6'd13;
    localparam logic [IDX_W-1:0] IX_DMODE    = 6'd14;
    localparam logic [IDX_W-1:0] IX_RET      = 6'd15;
    localparam logic [IDX_W-1:0] IX_ERR_SUM  = 6'd16;
    localparam logic [IDX_W-1:0] IX_ERR_MASK = 6'd17;
    localparam logic [IDX_W-1:0] IX_CMODE_D  = 6'd18;
    localparam logic [IDX_W-1:0] IX_CMODE_M  = 6'd19;
    localparam logic [IDX_W-1:0] IX_ASPACE   = 6'd20;
    localparam logic [IDX_W-1:0] IX_PTB_I    = 6'd21;
    localparam logic [IDX_W-1:0] IX_PTB_D    = 6'd22;
    localparam logic [IDX_W-1:0] IX_CYCLES   = 6'd23;
    localparam logic [IDX_W-1:0] IX_DPTE     = 6'd24;
    localparam logic [IDX_W-1:0] IX_INTR_ID  = 6'd32;
    localparam logic [IDX_W-1:0] IX_MEM_STAT = 6'd33;
    localparam logic [IDX_W-1:0] IX_INV_IA   = 6'd40;
    localparam logic [IDX_W-1:0] IX_INV_DA   = 6'd41;
    localparam logic [IDX_W-1:0] IX_INV_I1   = 6'd42;
    localparam logic [IDX_W-1:0] IX_INV_D1   = 6'd43;
    localparam logic [IDX_W-1:0] IX_DTAG     = 6'd44;

    localparam logic [DATA_W-1:0] M_ALL   = '1;
    localparam logic [DATA_W-1:0] M_NONE  = '0;
    localparam logic [DATA_W-1:0] M_LEVEL = 64'h1f;
    localparam logic [DATA_W-1:0] M_TRAP  = 64'hf;
    localparam logic [DATA_W-1:0] M_MODE  = 64'h18;
    localparam logic [DATA_W-1:0] M_CMODE = 64'h3f;
    localparam logic [DATA_W-1:0] M_ASP   = 64'h7f0;
    localparam logic [DATA_W-1:0] M_PTB   = 64'hffff_ffff_c000_0000;
    localparam logic [DATA_W-1:0] M_RET   = ~64'h2;
    localparam logic [DATA_W-1:0] MISC_RST = 64'h6;

    typedef enum logic [2:0] {
        OP_NONE, OP_INV_IA, OP_INV_DA, OP_INV_I1, OP_INV_D1, OP_INS_D
    } op_e;

    typedef struct packed {
        logic              known;
        logic              rd_ok;
        logic              wr_ok;
        logic              merge_cnt;
        op_e               op;
        logic [DATA_W-1:0] mask;
    } attr_t;

    // Build one attribute record.
    function automatic attr_t mk(input logic rd, input logic wr,
                                 input logic [DATA_W-1:0] m,
                                 input op_e o, input logic mc);
        attr_t a;
        a.known     = 1'b1;
        a.rd_ok     = rd;
        a.wr_ok     = wr;
        a.merge_cnt = mc;
        a.op        = o;
        a.mask      = m;
        return a;
    endfunction

    // Attribute decode for every index; unknown indices get known=0.
    function automatic attr_t attr_of(input logic [IDX_W-1:0] i);
        attr_t a;
        a.known = 1'b0; a.rd_ok = 1'b0; a.wr_ok = 1'b0;
        a.merge_cnt = 1'b0; a.op = OP_NONE; a.mask = M_NONE;
        if (int'(i) < SCRATCH_N) a = mk(1'b1, 1'b1, M_ALL, OP_NONE, 1'b0);
        case (i)
            IX_BASE, IX_MISC, IX_DPTE:
                a = mk(1'b1, 1'b1, M_ALL, OP_NONE, 1'b0);
            IX_LEVEL:               a = mk(1'b1, 1'b1, M_LEVEL, OP_NONE, 1'b0);
            IX_TRAP_REQ, IX_TRAP_EN: a = mk(1'b1, 1'b1, M_TRAP, OP_NONE, 1'b0);
            IX_IMODE, IX_DMODE:     a = mk(1'b1, 1'b1, M_MODE, OP_NONE, 1'b0);
            IX_RET:                 a = mk(1'b1, 1'b1, M_RET, OP_NONE, 1'b0);
            IX_ERR_SUM, IX_ERR_MASK: a = mk(1'b1, 1'b1, M_NONE, OP_NONE, 1'b0);
            IX_CMODE_D, IX_CMODE_M: a = mk(1'b1, 1'b1, M_CMODE, OP_NONE, 1'b0);
            IX_ASPACE:              a = mk(1'b1, 1'b1, M_ASP, OP_NONE, 1'b0);
            IX_PTB_I, IX_PTB_D:     a = mk(1'b1, 1'b1, M_PTB, OP_NONE, 1'b0);
            IX_CYCLES:              a = mk(1'b1, 1'b1, M_ALL, OP_NONE, 1'b1);
            IX_INTR_ID, IX_MEM_STAT: a = mk(1'b1, 1'b0, M_NONE, OP_NONE, 1'b0);
            IX_INV_IA:              a = mk(1'b0, 1'b1, M_NONE, OP_INV_IA, 1'b0);
            IX_INV_DA:              a = mk(1'b0, 1'b1, M_NONE, OP_INV_DA, 1'b0);
            IX_INV_I1:              a = mk(1'b0, 1'b1, M_ALL, OP_INV_I1, 1'b0);
            IX_INV_D1:              a = mk(1'b0, 1'b1, M_ALL, OP_INV_D1, 1'b0);
            IX_DTAG:                a = mk(1'b0, 1'b1, M_ALL, OP_INS_D, 1'b0);
            default: ;
        endcase
        return a;
    endfunction

    // Field accessors so users only decode what they need.
    function automatic logic can_read(input logic [IDX_W-1:0] i);
        attr_t a;
        a = attr_of(i);
        return a.rd_ok;
    endfunction

    function automatic logic can_write(input logic [IDX_W-1:0] i);
        attr_t a;
        a = attr_of(i);
        return a.wr_ok;
    endfunction

    function automatic logic merges_cnt(input logic [IDX_W-1:0] i);
        attr_t a;
        a = attr_of(i);
        return a.merge_cnt;
    endfunction

    function automatic op_e op_of(input logic [IDX_W-1:0] i);
        attr_t a;
        a = attr_of(i);
        return a.op;
    endfunction

    // Reset value per index.
    function automatic logic [DATA_W-1:0] reset_of(input logic [IDX_W-1:0] i,
                                                   input logic [DATA_W-1:0] id);
        if (i == IX_MISC)           return MISC_RST;
        if (int'(i) == ID_SLOT)     return id;
        return '0;
    endfunction

endpackage

// File: rtl/ctrlreg_cycle.sv
// Free-running cycle counter feeding the low half of the cycle register.
// Assumes wrap-around at 2**CNT_W is acceptable.
module ctrlreg_cycle
    import ctrlreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);

    // Count every edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // R8: the counter advances by exactly one per edge
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/ctrlreg_store.sv
// Register storage: one flop row per writable index, with the index's
// write mask applied on every write. Read-only and unknown indices are
// constants. Assumes at most one write per cycle.
module ctrlreg_store
    import ctrlreg_pkg::*;
#(
    parameter logic [DATA_W-1:0] CPU_ID = '0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q [NIDX]
);

    for (genvar g = 0; g < NIDX; g++) begin : g_slot
        localparam attr_t             A   = attr_of(IDX_W'(g));
        localparam logic [DATA_W-1:0] RST = reset_of(IDX_W'(g), CPU_ID);
        if (A.known && A.wr_ok) begin : g_flop
            logic hit;
            assign hit = wr_en && (wr_idx == IDX_W'(g));
            // Masked capture of the written data.
            always_ff @(posedge clk) begin
                if (!rst_n)   q[g] <= RST;
                else if (hit) q[g] <= wr_data & A.mask;
            end
            // R2: masked-out bits never become set (R3, R4 follow from the mask)
            p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
                hit |=> (q[g] & ~A.mask) == '0);
        end else begin : g_const
            assign q[g] = RST;
        end
    end

endmodule

// File: rtl/ctrlreg_ops.sv
// Command pulse generator: turns accepted writes to invalidate and tag
// indices into one-cycle pulses with address and entry payload.
module ctrlreg_ops
    import ctrlreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  op_e               op,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] pte_now,
    output logic              inv_i_all,
    output logic              inv_d_all,
    output logic              inv_i_one,
    output logic              inv_d_one,
    output logic              ins_d,
    output logic [DATA_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_pte
);

    logic active;
    assign active = go && (op != OP_NONE);

    // Register pulses for one cycle; payload is held between commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_i_all <= 1'b0; inv_d_all <= 1'b0;
            inv_i_one <= 1'b0; inv_d_one <= 1'b0;
            ins_d     <= 1'b0;
            op_addr   <= '0;   op_pte    <= '0;
        end else begin
            inv_i_all <= active && (op == OP_INV_IA);
            inv_d_all <= active && (op == OP_INV_DA);
            inv_i_one <= active && (op == OP_INV_I1);
            inv_d_one <= active && (op == OP_INV_D1);
            ins_d     <= active && (op == OP_INS_D);
            if (active) begin
                op_addr <= data;
                op_pte  <= pte_now;
            end
        end
    end

    // R9: never two commands at once
    p_pulse_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inv_i_all, inv_d_all, inv_i_one, inv_d_one, ins_d}));

    // R10: payload only moves with a command
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(op_addr));

endmodule

// File: rtl/ctrlreg_file.sv
// Top: control register file with a registered read port, a write port
// with per-index rules and fault flags, a cycle-merged register and
// translation-buffer command pulses. Reads see state before a same-cycle write.
module ctrlreg_file
    import ctrlreg_pkg::*;
#(
    parameter logic [63:0] CPU_ID = 64'h0
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic [5:0]  rd_idx,
    output logic [63:0] rd_data,
    output logic        rd_fault,
    input  logic        wr_en,
    input  logic [5:0]  wr_idx,
    input  logic [63:0] wr_data,
    output logic        wr_fault,
    output logic        inv_i_all,
    output logic        inv_d_all,
    output logic        inv_i_one,
    output logic        inv_d_one,
    output logic        ins_d,
    output logic [63:0] op_addr,
    output logic [63:0] op_pte
);

    logic [DATA_W-1:0] q [NIDX];
    logic [CNT_W-1:0]  cnt;
    logic              wr_ok, rd_ok, rd_merge, wr_go;
    op_e               wr_op;
    logic [DATA_W-1:0] rd_word;

    // Decode the rules of both requested indices.
    always_comb begin
        wr_ok    = can_write(wr_idx);
        wr_op    = op_of(wr_idx);
        rd_ok    = can_read(rd_idx);
        rd_merge = merges_cnt(rd_idx);
        wr_go    = wr_en && wr_ok;
    end

    ctrlreg_store #(.CPU_ID(CPU_ID)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_go),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .q       (q)
    );

    ctrlreg_cycle i_cycle (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt)
    );

    ctrlreg_ops i_ops (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (wr_go),
        .op        (wr_op),
        .data      (wr_data),
        .pte_now   (q[IX_DPTE]),
        .inv_i_all (inv_i_all),
        .inv_d_all (inv_d_all),
        .inv_i_one (inv_i_one),
        .inv_d_one (inv_d_one),
        .ins_d     (ins_d),
        .op_addr   (op_addr),
        .op_pte    (op_pte)
    );

    // Select the read word, merging the live count where required.
    always_comb begin
        if (!rd_ok)        rd_word = '0;
        else if (rd_merge) rd_word = {q[rd_idx][DATA_W-1:CNT_W], cnt};
        else               rd_word = q[rd_idx];
    end

    // Register read result and fault; hold between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_fault <= 1'b0;
        end else if (rd_en) begin
            rd_data  <= rd_word;
            rd_fault <= !rd_ok;
        end
    end

    // Registered write-refusal flag, one cycle per refused write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_fault <= 1'b0;
        else        wr_fault <= wr_en && !wr_ok;
    end

    // R6: a refused read returns zero data
    p_rd_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault |-> rd_data == '0);

    // R7: a refused write starts no command
    p_wr_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fault |-> !(inv_i_all || inv_d_all || inv_i_one || inv_d_one || ins_d));

    // R12: read outputs move only after a read request
    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(rd_en) |-> $stable(rd_data) && $stable(rd_fault));

endmodule

// File: tb/test_ctrlreg_file.sv
module test_ctrlreg_file;

    localparam logic [63:0] ID = 64'h0000_00C0_FFEE_003C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        rd_fault;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        wr_fault;
    logic        inv_i_all, inv_d_all, inv_i_one, inv_d_one, ins_d;
    logic [63:0] op_addr, op_pte;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] bc;
    logic [63:0] model [64];

    always #5 clk = ~clk;

    ctrlreg_file #(.CPU_ID(ID)) i_ctrlreg_file (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_fault(rd_fault),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_fault(wr_fault),
        .inv_i_all(inv_i_all), .inv_d_all(inv_d_all), .inv_i_one(inv_i_one),
        .inv_d_one(inv_d_one), .ins_d(ins_d), .op_addr(op_addr), .op_pte(op_pte)
    );

    // Edges since reset, kept by the bench for the cycle register (R8).
    always @(posedge clk) begin
        if (!rst_n) bc <= 0;
        else        bc <= bc + 1;
    end

    function automatic bit b_known(int i);
        return (i <= 24) || i == 32 || i == 33 || (i >= 40 && i <= 44);
    endfunction
    function automatic bit b_rd(int i);
        return b_known(i) && !(i >= 40);
    endfunction
    function automatic bit b_wr(int i);
        return b_known(i) && i != 32 && i != 33;
    endfunction
    function automatic logic [63:0] b_mask(int i);
        case (i)
            10: return 64'h1f;
            11, 12: return 64'hf;
            13, 14: return 64'h18;
            15: return ~64'h2;
            16, 17, 40, 41: return 64'h0;
            18, 19: return 64'h3f;
            20: return 64'h7f0;
            21, 22: return 64'hffff_ffff_c000_0000;
            default: return '1;
        endcase
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_rd(int i);
        if (!b_known(i)) return "R7";
        if (!b_rd(i))    return "R6";
        if (i == 23)     return "R8";
        if (i >= 10 && i <= 22 && i != 15 && i != 16 && i != 17) return "R2";
        if (i == 15)     return "R3";
        if (i == 16 || i == 17) return "R4";
        if (i == 32 || i == 33) return "R5";
        return "R13";
    endfunction

    task automatic do_read(int i, string req);
        logic [63:0] exp;
        @(negedge clk);
        rd_en = 1'b1; rd_idx = 6'(i);
        @(negedge clk);
        rd_en = 1'b0;
        if (!b_rd(i))    exp = '0;
        else if (i == 23) exp = {model[23][63:32], bc - 32'd1};
        else             exp = model[i];
        check(req, $sformatf("read data idx %0d", i), rd_data, exp);
        check(req, $sformatf("read fault idx %0d", i), 64'(rd_fault), 64'(!b_rd(i)));
    endtask

    task automatic do_write(int i, logic [63:0] d);
        logic [63:0] pte;
        string       rq;
        pte = model[24];
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(i); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (b_wr(i)) model[i] = d & b_mask(i);
        rq = !b_known(i) ? "R7" : (!b_wr(i) ? "R5" : "R9");
        check(rq, $sformatf("wr_fault idx %0d", i), 64'(wr_fault), 64'(!b_wr(i)));
        check("R9", $sformatf("inv_i_all idx %0d", i), 64'(inv_i_all), 64'(i == 40));
        check("R9", $sformatf("inv_d_all idx %0d", i), 64'(inv_d_all), 64'(i == 41));
        check("R10", $sformatf("inv_i_one idx %0d", i), 64'(inv_i_one), 64'(i == 42));
        check("R10", $sformatf("inv_d_one idx %0d", i), 64'(inv_d_one), 64'(i == 43));
        check("R11", $sformatf("ins_d idx %0d", i), 64'(ins_d), 64'(i == 44));
        if (i >= 40 && i <= 44)
            check("R10", $sformatf("op_addr idx %0d", i), op_addr, d);
        if (i == 44)
            check("R11", "op_pte", op_pte, pte);
    endtask

    task automatic read_sweep();
        for (int i = 0; i < 64; i++) do_read(i, req_rd(i));
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        model[9] = 64'h6;
        model[7] = ID;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle after reset
        check("R1", "rd_data after reset", rd_data, '0);
        check("R1", "rd_fault after reset", 64'(rd_fault), 0);
        check("R1", "wr_fault after reset", 64'(wr_fault), 0);
        check("R1", "pulses after reset",
              64'({inv_i_all, inv_d_all, inv_i_one, inv_d_one, ins_d}), 0);
        // R1: reset contents of every index
        for (int i = 0; i < 64; i++) do_read(i, (i == 23) ? "R8" : "R1");

        // R2 R3 R4 R5 R7 R9..R11: all-ones writes, then read back
        for (int i = 0; i < 64; i++) do_write(i, '1);
        read_sweep();

        // R13 and masks again with an index-dependent pattern
        for (int i = 0; i < 64; i++)
            do_write(i, {32'hA5C3_0F96 ^ 32'(i * 32'h0101_0101), 32'h1234_567A + 32'(i * 7)});
        read_sweep();

        // R3: bit 1 forced low with only that bit set
        do_write(15, 64'h2);
        do_read(15, "R3");
        // R4: clear-on-write with nonzero data
        do_write(16, 64'hDEAD_BEEF_0000_0001);
        do_read(16, "R4");

        // R12: read and write the same index in one cycle
        do_write(2, 64'h1111_2222_3333_4444);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = 6'd2;
        wr_en = 1'b1; wr_idx = 6'd2; wr_data = 64'h5555_6666_7777_8888;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R12", "same-cycle read returns old", rd_data, 64'h1111_2222_3333_4444);
        model[2] = 64'h5555_6666_7777_8888;
        do_read(2, "R12");
        // R12: data held while no read is requested
        @(negedge clk);
        @(negedge clk);
        check("R12", "rd_data held", rd_data, model[2]);

        // R8: cycle register at two distant times
        do_write(23, 64'hCAFE_F00D_9999_9999);
        do_read(23, "R8");
        repeat (37) @(negedge clk);
        do_read(23, "R8");

        // R11: insert payload follows the latest entry value
        do_write(24, 64'h0BAD_C0DE_1357_9BDF);
        do_write(44, 64'h0000_7777_0000_2000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule